// File: doc/BRIEF.md
# Shared-Timebase PWM Generator with Output Break

This block drives up to four pulse-width-modulated pins, each with a complementary partner pin, from a single up-counter. A shared prescaler divides the input clock. A shared reload value sets where the counter wraps. Each channel compares the counter against its own compare value. The pin is active while the counter is below that value.

Software programs the block through a word-wide register port with a write strobe and a combinational read. Compare values and the prescaler are double-buffered and move into the working copies only at an update event. An update event is either a counter wrap or a software request. The reload value can be double-buffered or take effect at once.

A main output enable gates every pin. Break inputs can clear it asynchronously to the counter's progress. Each break input has its own filter, and the main enable stays cleared until software sets it again. The synthesis parameters fix how many channel slots, complementary outputs and break inputs are really built. Enable bits of slots that are not built read back as zero, so software can discover the configuration.

Top module: `pwm_break_gen`

## Requirements
- R1: With prescaler value P (register 2) and reload value A (register 3), the counter holds each value for P+1 clocks and counts 0..A. The output period is (P+1)*(A+1) clocks, and a compare value C gives an active time of C*(P+1) clocks.
- R2: A compare value above the reload value keeps the output active for the whole period. A compare value of 0 keeps it inactive.
- R3: A write to compare register 8+n changes nothing until the next update event. Writing 1 to bit 0 of register 1 forces an update event: it loads the prescaler, reload and compare working copies and restarts the prescaler and counter at 0.
- R4: Control register 0 holds three bits: bit 0 runs the counter, bit 1 double-buffers the reload value and bit 2 is the main output enable. With bit 1 set, a new reload value waits for the next update event. With bit 1 clear, it applies at once.
- R5: Register 4 gives channel n the bits 4n..4n+3, in this order: output enable, output polarity, complementary enable, complementary polarity. A polarity bit of 1 inverts the pin. The complementary pin is active while the channel is not active.
- R6: Configuration bits of channels at or above CH_IMPL read back 0 and ignore writes of 1, and so do all complementary bits when COMP_IMPL is 0. The same holds for the whole field of break inputs at or above BRK_IMPL.
- R7: While the main output enable is 0, every pin sits at the level of its polarity bit. While bit 0 of register 0 is 0, the counter holds its value. After reset all registers and pins are 0.
- R8: Register 5 gives break input k the bits 8k..8k+5, in this order: enable, active level (1 = high), filter F in bits 8k+2..8k+5. After a two-flop synchronizer, an enabled break input that is seen at its active level for F+1 consecutive clocks clears the main output enable. Shorter pulses, and inputs that are not enabled, change nothing.
- R9: After a break, the main output enable stays 0 until software writes 1 to it. A write made while the break condition still holds is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| brk_i | input | BRK_SLOTS | Break inputs |
| pwm_o | output | CH_SLOTS | Channel outputs |
| pwm_n_o | output | CH_SLOTS | Complementary outputs |

## Verification
The bench fixes the counter in place and shows that a compare write is invisible until a forced update. A design that loaded compare values directly would change the pin at once. It starts the counter right after lowering the reload value, with double-buffering on and then off. The pin's active count over one old period tells whether the design applied the new value too early or too late.

Break pulses of exactly F and F+1 clocks test the filter threshold, where an off-by-one would either trip on glitches or need an extra clock. The bench also writes the main enable while the break input is still held. A design that let software win that race would re-enable the pins into a fault.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_UPDATE = 1;
  localparam int ADDR_PSC    = 2;
  localparam int ADDR_RELOAD = 3;
  localparam int ADDR_OUTCFG = 4;
  localparam int ADDR_BRKCFG = 5;
  localparam int ADDR_CMP0   = 8;

  localparam int CH_GRP_W  = 4;
  localparam int BRK_GRP_W = 8;
  localparam int FILT_W    = 4;

  typedef struct packed {
    logic cpol;
    logic cen;
    logic pol;
    logic en;
  } ch_cfg_t;

  typedef struct packed {
    logic [FILT_W-1:0] filt;
    logic              pol;
    logic              en;
  } brk_cfg_t;

  localparam int BRK_CFG_W = $bits(brk_cfg_t);

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             arpe_i,
  input  logic             ug_i,
  input  logic [PSC_W-1:0] psc_pre_i,
  input  logic [CNT_W-1:0] arr_pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o
);
  logic [PSC_W-1:0] pcnt_q, pcnt_d, psc_q, psc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, arr_sh_q, arr_sh_d, arr_eff;
  logic             tick, wrap, upd;

  always_comb begin
    arr_eff  = arpe_i ? arr_sh_q : arr_pre_i;
    tick     = run_i && (pcnt_q == psc_q);
    wrap     = tick && (cnt_q >= arr_eff);
    upd      = wrap || ug_i;
    pcnt_d   = pcnt_q;
    cnt_d    = cnt_q;
    psc_d    = psc_q;
    arr_sh_d = arr_sh_q;
    if (ug_i) begin
      pcnt_d = '0;
      cnt_d  = '0;
    end else if (run_i) begin
      if (tick) begin
        pcnt_d = '0;
        cnt_d  = wrap ? '0 : cnt_q + 1'b1;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
    if (upd) begin
      psc_d    = psc_pre_i;
      arr_sh_d = arr_pre_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q   <= '0;
      cnt_q    <= '0;
      psc_q    <= '0;
      arr_sh_q <= '0;
    end else begin
      pcnt_q   <= pcnt_d;
      cnt_q    <= cnt_d;
      psc_q    <= psc_d;
      arr_sh_q <= arr_sh_d;
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd;

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !ug_i) |=> $stable(cnt_q));

  // R3
  ug_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ug_i |=> (cnt_q == '0 && pcnt_q == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel import pwm_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ccr_we_i,
  input  logic [CNT_W-1:0] ccr_wdata_i,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             moe_i,
  input  ch_cfg_t          cfg_i,
  output logic [CNT_W-1:0] ccr_pre_o,
  output logic             pwm_o,
  output logic             pwm_n_o
);
  logic [CNT_W-1:0] ccr_pre_q, ccr_pre_d, ccr_act_q, ccr_act_d;
  logic             hit;

  always_comb begin
    ccr_pre_d = ccr_we_i ? ccr_wdata_i : ccr_pre_q;
    ccr_act_d = upd_i ? ccr_pre_q : ccr_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_pre_q <= '0;
      ccr_act_q <= '0;
    end else begin
      ccr_pre_q <= ccr_pre_d;
      ccr_act_q <= ccr_act_d;
    end
  end

  assign hit       = cnt_i < ccr_act_q;
  assign pwm_o     = (moe_i & cfg_i.en & hit) ^ cfg_i.pol;
  assign pwm_n_o   = (moe_i & cfg_i.cen & ~hit) ^ cfg_i.cpol;
  assign ccr_pre_o = ccr_pre_q;

  // R7
  moe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !moe_i |-> (pwm_o == cfg_i.pol && pwm_n_o == cfg_i.cpol));

  // R3
  ccr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(ccr_act_q));

  // R2
  zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_act_q == '0) |-> (pwm_o == cfg_i.pol));
endmodule

// File: rtl/pwm_brk_filter.sv
module pwm_brk_filter import pwm_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     brk_i,
  input  brk_cfg_t cfg_i,
  output logic     trip_o
);
  logic              s1_q, s2_q, active;
  logic [FILT_W-1:0] run_q, run_d;

  always_comb begin
    active = cfg_i.en && (s2_q == cfg_i.pol);
    if (!active)           run_d = '0;
    else if (run_q != '1)  run_d = run_q + 1'b1;
    else                   run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      run_q <= '0;
    end else begin
      s1_q  <= brk_i;
      s2_q  <= s1_q;
      run_q <= run_d;
    end
  end

  assign trip_o = active && (run_q >= cfg_i.filt);

  // R8
  brk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.en |-> !trip_o);
endmodule

// File: rtl/pwm_break_gen.sv
module pwm_break_gen import pwm_pkg::*; #(
  parameter int CH_SLOTS  = 4,
  parameter int CH_IMPL   = 3,
  parameter int COMP_IMPL = 1,
  parameter int BRK_SLOTS = 2,
  parameter int BRK_IMPL  = 1,
  parameter int CNT_W     = 16,
  parameter int PSC_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [BRK_SLOTS-1:0] brk_i,
  output logic [CH_SLOTS-1:0]  pwm_o,
  output logic [CH_SLOTS-1:0]  pwm_n_o
);
  localparam int COMP_ON = (COMP_IMPL != 0) ? 1 : 0;

  logic rst_n_s;
  logic wr_ctrl, wr_upd, wr_psc, wr_rld, wr_ocfg, wr_brk, ug;
  logic run_q, run_d, arpe_q, arpe_d, moe_q, moe_d;
  logic [PSC_W-1:0] psc_pre_q, psc_pre_d;
  logic [CNT_W-1:0] arr_pre_q, arr_pre_d, cnt;
  logic             upd, trip_any;
  ch_cfg_t  ch_cfg_q  [CH_SLOTS];
  ch_cfg_t  ch_cfg_d  [CH_SLOTS];
  brk_cfg_t brk_cfg_q [BRK_SLOTS];
  brk_cfg_t brk_cfg_d [BRK_SLOTS];
  logic [CH_SLOTS-1:0][CNT_W-1:0] ccr_pre;
  logic [CH_SLOTS-1:0]            ccr_we;
  logic [BRK_SLOTS-1:0]           trip;
  logic                           unused_wdata;

  pwm_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
  assign wr_upd  = reg_we && (reg_addr == ADDR_W'(ADDR_UPDATE));
  assign wr_psc  = reg_we && (reg_addr == ADDR_W'(ADDR_PSC));
  assign wr_rld  = reg_we && (reg_addr == ADDR_W'(ADDR_RELOAD));
  assign wr_ocfg = reg_we && (reg_addr == ADDR_W'(ADDR_OUTCFG));
  assign wr_brk  = reg_we && (reg_addr == ADDR_W'(ADDR_BRKCFG));
  assign ug      = wr_upd && reg_wdata[0];
  assign trip_any = |trip;
  assign unused_wdata = ^reg_wdata;

  // Next-state for control and configuration registers
  always_comb begin
    run_d     = wr_ctrl ? reg_wdata[0] : run_q;
    arpe_d    = wr_ctrl ? reg_wdata[1] : arpe_q;
    if (trip_any)     moe_d = 1'b0;
    else if (wr_ctrl) moe_d = reg_wdata[2];
    else              moe_d = moe_q;
    psc_pre_d = wr_psc ? reg_wdata[PSC_W-1:0] : psc_pre_q;
    arr_pre_d = wr_rld ? reg_wdata[CNT_W-1:0] : arr_pre_q;
    for (int c = 0; c < CH_SLOTS; c++) begin
      ch_cfg_d[c] = ch_cfg_q[c];
      if (wr_ocfg) begin
        ch_cfg_d[c] = ch_cfg_t'(reg_wdata[CH_GRP_W*c +: CH_GRP_W] &
          {{2{(c < CH_IMPL) && (COMP_ON == 1)}}, {2{c < CH_IMPL}}});
      end
    end
    for (int b = 0; b < BRK_SLOTS; b++) begin
      brk_cfg_d[b] = brk_cfg_q[b];
      if (wr_brk) begin
        brk_cfg_d[b] = (b < BRK_IMPL) ?
          brk_cfg_t'(reg_wdata[BRK_GRP_W*b +: BRK_CFG_W]) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      run_q     <= 1'b0;
      arpe_q    <= 1'b0;
      moe_q     <= 1'b0;
      psc_pre_q <= '0;
      arr_pre_q <= '0;
      for (int c = 0; c < CH_SLOTS; c++)  ch_cfg_q[c]  <= '0;
      for (int b = 0; b < BRK_SLOTS; b++) brk_cfg_q[b] <= '0;
    end else begin
      run_q     <= run_d;
      arpe_q    <= arpe_d;
      moe_q     <= moe_d;
      psc_pre_q <= psc_pre_d;
      arr_pre_q <= arr_pre_d;
      for (int c = 0; c < CH_SLOTS; c++)  ch_cfg_q[c]  <= ch_cfg_d[c];
      for (int b = 0; b < BRK_SLOTS; b++) brk_cfg_q[b] <= brk_cfg_d[b];
    end
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADDR_CTRL):   reg_rdata[2:0] = {moe_q, arpe_q, run_q};
      ADDR_W'(ADDR_PSC):    reg_rdata[PSC_W-1:0] = psc_pre_q;
      ADDR_W'(ADDR_RELOAD): reg_rdata[CNT_W-1:0] = arr_pre_q;
      ADDR_W'(ADDR_OUTCFG): begin
        for (int c = 0; c < CH_SLOTS; c++)
          reg_rdata[CH_GRP_W*c +: CH_GRP_W] = ch_cfg_q[c];
      end
      ADDR_W'(ADDR_BRKCFG): begin
        for (int b = 0; b < BRK_SLOTS; b++)
          reg_rdata[BRK_GRP_W*b +: BRK_CFG_W] = brk_cfg_q[b];
      end
      default: begin
        for (int c = 0; c < CH_SLOTS; c++)
          if (reg_addr == ADDR_W'(ADDR_CMP0 + c))
            reg_rdata[CNT_W-1:0] = ccr_pre[c];
      end
    endcase
  end

  pwm_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst_n(rst_n_s), .run_i(run_q), .arpe_i(arpe_q), .ug_i(ug),
    .psc_pre_i(psc_pre_q), .arr_pre_i(arr_pre_q), .cnt_o(cnt), .upd_o(upd)
  );

  for (genvar c = 0; c < CH_SLOTS; c++) begin : g_ch
    assign ccr_we[c] = (c < CH_IMPL) && reg_we &&
                       (reg_addr == ADDR_W'(ADDR_CMP0 + c));
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n_s), .ccr_we_i(ccr_we[c]),
      .ccr_wdata_i(reg_wdata[CNT_W-1:0]), .upd_i(upd), .cnt_i(cnt),
      .moe_i(moe_q), .cfg_i(ch_cfg_q[c]), .ccr_pre_o(ccr_pre[c]),
      .pwm_o(pwm_o[c]), .pwm_n_o(pwm_n_o[c])
    );
  end

  for (genvar b = 0; b < BRK_SLOTS; b++) begin : g_brk
    pwm_brk_filter u_flt (
      .clk(clk), .rst_n(rst_n_s), .brk_i(brk_i[b]),
      .cfg_i(brk_cfg_q[b]), .trip_o(trip[b])
    );
  end

  // R9
  brk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    trip_any |=> !moe_q);

  // R9
  moe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!moe_q && !wr_ctrl) |=> !moe_q);
endmodule

// File: tb/sim_pwm_break_gen.sv
module sim_pwm_break_gen;
  import pwm_pkg::*;

  logic        clk, rst_n, reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [1:0]  brk_i;
  logic [3:0]  pwm_o, pwm_n_o;
  logic [7:0]  obs;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { string tag; int val; } item_t;
  item_t exp_q[$];
  int    got_q[$];
  event  obs_ev;

  pwm_break_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brk_i(brk_i),
    .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
  );

  assign obs = {pwm_n_o, pwm_o};

  initial clk = 0;
  always #10 clk = ~clk;

  // Scoreboard monitor
  initial forever begin
    @(obs_ev);
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      item_t e;
      int g;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      checks++;
      if (g != e.val) begin
        errors++;
        $display("FAIL %s: actual %0d expected %0d", e.tag, g, e.val);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    exp_q.push_back('{tag, exp});
    got_q.push_back(act);
    -> obs_ev;
    #0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic measure(input int idx, output int hi, output int per);
    int prev, cur, n;
    prev = obs[idx]; n = 0;
    forever begin
      @(negedge clk); cur = obs[idx];
      if (!prev && cur) break;
      prev = cur; n++;
      if (n > 2000) break;
    end
    hi = 1; per = 1; prev = 1; n = 0;
    forever begin
      @(negedge clk); cur = obs[idx];
      if (cur && !prev) break;
      if (cur) hi++;
      per++; prev = cur; n++;
      if (n > 2000) break;
    end
  endtask

  task automatic count_hi(input int idx, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (obs[idx]) hi++;
      @(negedge clk);
    end
  endtask

  task automatic brk_pulse(input int k, input bit lvl, input int n);
    @(negedge clk); brk_i[k] = lvl;
    repeat (n) @(negedge clk);
    brk_i[k] = ~lvl;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, hi, per;
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; brk_i = 2'b00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R7 reset state
    rd(ADDR_CTRL, v);           chk("R7 reset ctrl", v, 0);
    chk("R7 reset pins", int'(obs), 0);

    // R6 unimplemented bits ignore writes
    wr(ADDR_OUTCFG, 32'hFFFF);
    rd(ADDR_OUTCFG, v);         chk("R6 outcfg readback", v, 32'h0FFF);
    wr(ADDR_BRKCFG, 32'h3F3F);
    rd(ADDR_BRKCFG, v);         chk("R6 brkcfg readback", v, 32'h003F);
    wr(ADDR_BRKCFG, 0);

    // R1 main pattern
    wr(ADDR_PSC, 1); wr(ADDR_RELOAD, 9);
    wr(ADDR_CMP0, 3); wr(ADDR_CMP0 + 1, 3);
    wr(ADDR_OUTCFG, 32'h0035);
    wr(ADDR_UPDATE, 1);
    wr(ADDR_CTRL, 5);
    rd(ADDR_CMP0, v);           chk("R3 cmp0 readback", v, 3);
    measure(0, hi, per);
    chk("R1 period psc1 arr9", per, 20);
    chk("R1 active psc1 cmp3", hi, 6);
    // R5 polarity and complementary
    measure(1, hi, per);        chk("R5 inverted high time", hi, 14);
    measure(4, hi, per);        chk("R5 complementary high time", hi, 14);
    chk("R5 complementary period", per, 20);

    // R1 second pattern
    wr(ADDR_PSC, 0); wr(ADDR_RELOAD, 4); wr(ADDR_CMP0, 2);
    wr(ADDR_UPDATE, 1);
    measure(0, hi, per);
    chk("R1 period psc0 arr4", per, 5);
    chk("R1 active psc0 cmp2", hi, 2);
    wr(ADDR_PSC, 1); wr(ADDR_RELOAD, 9); wr(ADDR_CMP0, 3);
    wr(ADDR_UPDATE, 1);

    // R2 compare above reload / zero
    wr(ADDR_CMP0 + 2, 15); wr(ADDR_OUTCFG, 32'h0135); wr(ADDR_UPDATE, 1);
    count_hi(2, 40, hi);        chk("R2 cmp above reload", hi, 40);
    wr(ADDR_CMP0 + 2, 0); wr(ADDR_UPDATE, 1);
    count_hi(2, 40, hi);        chk("R2 cmp zero", hi, 0);

    // R3 compare preload with counter stopped
    wr(ADDR_CTRL, 4); wr(ADDR_UPDATE, 1);
    wr(ADDR_CMP0, 0);
    chk("R3 cmp write held", int'(obs[0]), 1);
    wr(ADDR_UPDATE, 1);
    chk("R3 forced update applies", int'(obs[0]), 0);
    wr(ADDR_CMP0, 3); wr(ADDR_UPDATE, 1);
    // R7 counter holds while stopped
    count_hi(0, 30, hi);        chk("R7 stopped counter holds", hi, 30);

    // R4 reload double-buffered
    wr(ADDR_CMP0, 7); wr(ADDR_UPDATE, 1);
    wr(ADDR_CTRL, 6); wr(ADDR_RELOAD, 2); wr(ADDR_CTRL, 7);
    count_hi(0, 20, hi);        chk("R4 buffered reload waits", hi, 14);
    // R4 reload direct
    wr(ADDR_CTRL, 4); wr(ADDR_RELOAD, 9); wr(ADDR_UPDATE, 1);
    wr(ADDR_RELOAD, 2); wr(ADDR_CTRL, 5);
    count_hi(0, 20, hi);        chk("R4 direct reload immediate", hi, 20);
    wr(ADDR_RELOAD, 9); wr(ADDR_CMP0, 3); wr(ADDR_UPDATE, 1);

    // R7 main output enable gating
    wr(ADDR_CTRL, 1);
    chk("R7 pins inactive moe0", int'(obs), 32'h02);
    repeat (7) @(negedge clk);
    chk("R7 pins stay inactive", int'(obs), 32'h02);
    wr(ADDR_CTRL, 5);

    // R8 break filter threshold (F=3, active high)
    wr(ADDR_BRKCFG, 32'h0F);
    brk_pulse(0, 1, 3);
    repeat (10) @(negedge clk);
    rd(ADDR_CTRL, v);           chk("R8 short pulse ignored", (v >> 2) & 1, 1);
    brk_pulse(0, 1, 4);
    repeat (10) @(negedge clk);
    rd(ADDR_CTRL, v);           chk("R8 long pulse trips", (v >> 2) & 1, 0);
    chk("R8 pins inactive after break", int'(obs), 32'h02);

    // R9 sticky clear and break priority
    @(negedge clk); brk_i[0] = 1;
    repeat (8) @(negedge clk);
    wr(ADDR_CTRL, 5);
    rd(ADDR_CTRL, v);           chk("R9 write during break lost", (v >> 2) & 1, 0);
    brk_i[0] = 0;
    repeat (10) @(negedge clk);
    rd(ADDR_CTRL, v);           chk("R9 stays cleared", (v >> 2) & 1, 0);
    wr(ADDR_CTRL, 5);
    rd(ADDR_CTRL, v);           chk("R9 software re-enable", (v >> 2) & 1, 1);

    // R8 disabled break ignored
    wr(ADDR_BRKCFG, 32'h0E);
    brk_pulse(0, 1, 20);
    repeat (6) @(negedge clk);
    rd(ADDR_CTRL, v);           chk("R8 disabled break ignored", (v >> 2) & 1, 1);

    // R8 active-low break
    @(negedge clk); brk_i[0] = 1;
    wr(ADDR_BRKCFG, 32'h0D);
    repeat (10) @(negedge clk);
    rd(ADDR_CTRL, v);           chk("R8 active-low idle high", (v >> 2) & 1, 1);
    brk_pulse(0, 0, 6);
    repeat (8) @(negedge clk);
    rd(ADDR_CTRL, v);           chk("R8 active-low trips", (v >> 2) & 1, 0);
    wr(ADDR_BRKCFG, 0);

    #1;
    while (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      checks++; errors++;
      $display("FAIL %s: actual none expected %0d", e.tag, e.val);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule